// File: doc/BRIEF.md
# PHY Post-Reset Calibration Sequencer

This block retunes a high-speed PHY once its controller has come out of reset. A controller reset puts certain internal PHY registers back to their defaults. After that reset, the block sends three override writes through an external request/acknowledge write master. The writes go out in a fixed order:

1. The loss-of-signal detector bias and level.
2. The transmit boost level.
3. The receiver-detect measurement time.

The block chooses the third payload from a reference-clock frequency select code, which it captures when the sequence starts.

The block ends a run by raising `done`. It raises `err` together with `done` in two cases: a write came back with an error, or the frequency code had no known measurement time. Pulsing `start` again after a finished run repeats the whole list from the beginning.

Top module: `phy_cal_seq`

## Requirements
- R1: After reset, `done`, `err` and `wrReq` are all 0.
- R2: While `ctrlInReset` is 1, a `start` pulse has no effect: no write is requested and `done`/`err` keep their values.
- R3: The first write of every run uses address 0x0015 and data 0xA409. This data holds bias 5 in bits [15:13], the override enable in bit 10 and level 9 in bits [4:0].
- R4: The second write uses address 0x0012 and data 0xA000, which is boost level 5 in bits [15:13].
- R5: The third write uses address 0x1010, with the measurement time placed at bit 4.
  - `refSel` codes 0 (19.2 MHz) and 1 (20 MHz) give time 0x04.
  - Codes 2, 3 and 4 (24, 25, 26 MHz) give 0x08.
  - Codes 5 to 8 (48, 50, 52, 62.5 MHz) give 0x20.
  - Codes 9 and 10 (96, 100 MHz) give 0x40.
- R6: `wrReq` holds its address and data steady until a cycle with `wrAck` = 1. The next write is requested in the cycle after that acknowledge. After the last write, `wrReq` drops.
- R7: An acknowledge with `wrErr` = 1 ends the run: no further write is requested, and `done` and `err` both become 1 in the next cycle.
- R8: For `refSel` codes 11 to 15, only the first two writes are issued. The run then ends with `done` = 1 and `err` = 1.
- R9: A successful run ends with `done` = 1 and `err` = 0. A later accepted `start` clears both flags and reruns all writes. A `start` during a run is ignored.
- R10: `refSel` is captured when `start` is accepted. Changing it during a run does not alter the third write.
- R11: An acknowledge that arrives while no write is requested has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrlInReset | input | 1 | Controller still held in reset; blocks start |
| start | input | 1 | Begin (or repeat) the calibration list |
| refSel | input | 4 | Reference-clock frequency select code |
| wrReq | output | 1 | Write request to the handshake master |
| wrAddr | output | 16 | Internal PHY register address of the pending write |
| wrData | output | 16 | Data of the pending write |
| wrAck | input | 1 | Write master completed the pending write |
| wrErr | input | 1 | Completed write failed (valid with wrAck) |
| done | output | 1 | Sequence finished |
| err | output | 1 | Sequence finished with a failure or skipped write |

## Verification
`wrReq` and the first address are due one cycle after the clock edge that samples an accepted `start`. Each following address is due one cycle after the edge that samples an acknowledge. `done` and `err` are due one cycle after the last acknowledge, or after the one that carries an error.

The reference model advances on the same rising edges, working from queued write records. Every output is compared on the falling edge, so each comparison sees the values already registered for that cycle. The run-level checks on the final flags are taken once `done` is seen.

// File: rtl/phy_cal_pkg.sv
package phy_cal_pkg;

  typedef struct packed {
    logic launch;  // accept start: capture select, clear flags, index 0
    logic step;    // acked write without error, more to go
    logic finish;  // last write acked without error
    logic abort;   // acked write reported an error
  } seqStrobe_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seqState_t;

  localparam int unsigned NUM_WRITES = 3;
  localparam int unsigned IDX_W      = $clog2(NUM_WRITES);

  localparam logic [15:0] LOS_ADDR   = 16'h0015;
  localparam logic [15:0] LOS_DATA   = 16'hA409;
  localparam logic [15:0] BOOST_ADDR = 16'h0012;
  localparam logic [15:0] BOOST_DATA = 16'hA000;
  localparam logic [15:0] RXDET_ADDR = 16'h1010;
  localparam int unsigned RXDET_LSB  = 4;

  // Returns {supported, measurement time}
  function automatic logic [8:0] rxdetTime(input logic [3:0] sel);
    case (sel)
      4'd0, 4'd1:             rxdetTime = {1'b1, 8'h04};
      4'd2, 4'd3, 4'd4:       rxdetTime = {1'b1, 8'h08};
      4'd5, 4'd6, 4'd7, 4'd8: rxdetTime = {1'b1, 8'h20};
      4'd9, 4'd10:            rxdetTime = {1'b1, 8'h40};
      default:                rxdetTime = {1'b0, 8'h00};
    endcase
  endfunction

endpackage

// File: rtl/phy_cal_ctrl.sv
module phy_cal_ctrl
  import phy_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrlInReset,
  input  logic       start,
  input  logic       wrAck,
  input  logic       wrErr,
  input  logic       lastWrite,
  output logic       busy,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      SEQ_IDLE: begin
        if (start && !ctrlInReset) begin
          strobe.launch = 1'b1;
          stateNext     = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (wrAck) begin
          if (wrErr) begin
            strobe.abort = 1'b1;
            stateNext    = SEQ_IDLE;
          end else if (lastWrite) begin
            strobe.finish = 1'b1;
            stateNext     = SEQ_IDLE;
          end else begin
            strobe.step = 1'b1;
          end
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEQ_IDLE;
    else        state <= stateNext;
  end

  assign busy = (state == SEQ_RUN);

  // R2
  blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ctrlInReset) |=> !busy);

  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && wrAck) |=> !busy);

endmodule

// File: rtl/phy_cal_dp.sv
module phy_cal_dp
  import phy_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [SEL_W-1:0]  refSel,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              lastWrite,
  output logic              done,
  output logic              err
);

  localparam int unsigned LAST_IDX = NUM_WRITES - 1;

  logic [IDX_W-1:0] writeIdx;
  logic [SEL_W-1:0] selHeld;
  logic [8:0]       lookup;
  logic             selOk;

  assign lookup = rxdetTime(4'(selHeld));
  assign selOk  = lookup[8];

  // Without a known time the list is one entry shorter
  assign lastWrite = (writeIdx == IDX_W'(LAST_IDX)) ||
                     (!selOk && writeIdx == IDX_W'(LAST_IDX - 1));

  always_comb begin
    case (writeIdx)
      IDX_W'(0): begin
        wrAddr = ADDR_W'(LOS_ADDR);
        wrData = DATA_W'(LOS_DATA);
      end
      IDX_W'(1): begin
        wrAddr = ADDR_W'(BOOST_ADDR);
        wrData = DATA_W'(BOOST_DATA);
      end
      default: begin
        wrAddr = ADDR_W'(RXDET_ADDR);
        wrData = DATA_W'(lookup[7:0]) << RXDET_LSB;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      writeIdx <= '0;
      selHeld  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      if (strobe.launch) begin
        writeIdx <= '0;
        selHeld  <= refSel;
        done     <= 1'b0;
        err      <= 1'b0;
      end
      if (strobe.step)   writeIdx <= writeIdx + 1'b1;
      if (strobe.finish) begin
        done <= 1'b1;
        err  <= !selOk;
      end
      if (strobe.abort) begin
        done <= 1'b1;
        err  <= 1'b1;
      end
    end
  end

  // R8
  err_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.launch |=> $stable(selHeld));

endmodule

// File: rtl/phy_cal_seq.sv
module phy_cal_seq
  import phy_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrlInReset,
  input  logic              start,
  input  logic [SEL_W-1:0]  refSel,
  output logic              wrReq,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  input  logic              wrAck,
  input  logic              wrErr,
  output logic              done,
  output logic              err
);

  seqStrobe_t strobe;
  logic       lastWrite;
  logic       busy;

  phy_cal_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrlInReset(ctrlInReset),
    .start      (start),
    .wrAck      (wrAck),
    .wrErr      (wrErr),
    .lastWrite  (lastWrite),
    .busy       (busy),
    .strobe     (strobe)
  );

  phy_cal_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .SEL_W (SEL_W)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .refSel   (refSel),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .lastWrite(lastWrite),
    .done     (done),
    .err      (err)
  );

  assign wrReq = busy;

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrReq && !wrAck) |=> (wrReq && $stable(wrAddr) && $stable(wrData)));

  // R7
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrReq && wrAck && wrErr) |=> (done && err && !wrReq));

  // R3
  first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wrReq) |-> (wrAddr == ADDR_W'(LOS_ADDR) && wrData == DATA_W'(LOS_DATA)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wrReq);

endmodule

// File: tb/test_phy_cal_seq.sv
module test_phy_cal_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrlInReset = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  refSel = 4'd0;
  logic        wrReq;
  logic [15:0] wrAddr;
  logic [15:0] wrData;
  logic        wrAck = 1'b0;
  logic        wrErr = 1'b0;
  logic        done;
  logic        err;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  phy_cal_seq i_phy_cal_seq (
    .clk(clk), .rst_n(rst_n), .ctrlInReset(ctrlInReset), .start(start),
    .refSel(refSel), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .wrAck(wrAck), .wrErr(wrErr), .done(done), .err(err)
  );

  // Measurement time in the bench's own terms, from frequency in kHz
  function automatic int measFor(int sel);
    int khz;
    case (sel)
      0: khz = 19200;   1: khz = 20000;   2: khz = 24000;
      3: khz = 25000;   4: khz = 26000;   5: khz = 48000;
      6: khz = 50000;   7: khz = 52000;   8: khz = 62500;
      9: khz = 96000;   10: khz = 100000;
      default: khz = 0;
    endcase
    if (khz == 0) return -1;
    if (khz <= 20000) return 'h04;
    if (khz <= 26000) return 'h08;
    if (khz <= 62500) return 'h20;
    return 'h40;
  endfunction

  // Reference model
  int  mQueue[$];
  bit  mBusy, mDone, mErr, mSkip;

  always @(posedge clk) begin
    if (!rst_n) begin
      mQueue.delete(); mBusy = 0; mDone = 0; mErr = 0; mSkip = 0;
    end else if (!mBusy) begin
      if (start && !ctrlInReset) begin
        int mt;
        mt = measFor(int'(refSel));
        mQueue.delete();
        mQueue.push_back({16'h0015, 16'hA409});
        mQueue.push_back({16'h0012, 16'hA000});
        if (mt >= 0) mQueue.push_back({16'h1010, 16'(mt * 16)});
        mSkip = (mt < 0); mBusy = 1; mDone = 0; mErr = 0;
      end
    end else if (wrAck) begin
      if (wrErr) begin
        mQueue.delete(); mBusy = 0; mDone = 1; mErr = 1;
      end else begin
        void'(mQueue.pop_front());
        if (mQueue.size() == 0) begin
          mBusy = 0; mDone = 1; mErr = mSkip;
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R6 wrReq", int'(wrReq), int'(mBusy));
      check("R9 done", int'(done), int'(mDone));
      check("R7/R8 err", int'(err), int'(mErr));
      if (mBusy && mQueue.size() > 0) begin
        check("R3/R4/R5 wrAddr", int'(wrAddr), mQueue[0] >>> 16);
        check("R3/R4/R5 wrData", int'(wrData), mQueue[0] & 'hFFFF);
      end
    end
  end

  // Write master responder
  int ackDelay = 1;
  int errOn = -1;
  int wrCount = 0;
  int waitCnt = 0;
  always @(negedge clk) begin
    if (wrAck) begin
      wrAck <= 1'b0; wrErr <= 1'b0; wrCount <= wrCount + 1; waitCnt <= 0;
    end else if (wrReq) begin
      if (waitCnt >= ackDelay) begin
        wrAck <= 1'b1; wrErr <= (wrCount == errOn); waitCnt <= 0;
      end else waitCnt <= waitCnt + 1;
    end
  end

  task automatic pulseStart(input logic [3:0] sel);
    @(negedge clk); refSel = sel; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitDone(string tag);
    for (int i = 0; i < 60; i++) begin
      if (done) break;
      @(negedge clk);
    end
    check({tag, " done"}, int'(done), 1);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 done", int'(done), 0);
    check("R1 err", int'(err), 0);
    check("R1 wrReq", int'(wrReq), 0);
    rst_n = 1'b1;

    // R2: blocked while controller in reset
    ctrlInReset = 1'b1;
    pulseStart(4'd0);
    repeat (4) @(negedge clk);
    check("R2 no request", int'(wrReq), 0);
    check("R2 done unchanged", int'(done), 0);
    ctrlInReset = 1'b0;

    // R5/R8/R9: every select code, rerun after done
    for (int s = 0; s < 16; s++) begin
      ackDelay = s % 3;
      wrCount = 0;
      pulseStart(4'(s));
      waitDone("R5 code");
      check("R5/R8 err for code", int'(err), (measFor(s) < 0) ? 1 : 0);
      check("R5/R8 write count", wrCount, (measFor(s) < 0) ? 2 : 3);
    end

    // R7: error on second write
    errOn = 1; wrCount = 0; ackDelay = 2;
    pulseStart(4'd6);
    waitDone("R7");
    check("R7 err", int'(err), 1);
    repeat (3) @(negedge clk);
    check("R7 writes stopped", wrCount, 2);
    errOn = -1;

    // R10: select change mid-run; R9: start while busy ignored
    wrCount = 0; ackDelay = 3;
    pulseStart(4'd9);
    refSel = 4'd15;
    start = 1'b1; @(negedge clk); start = 1'b0;
    waitDone("R10");
    check("R10 err", int'(err), 0);
    check("R9 busy start ignored", wrCount, 3);

    // R11: stray acknowledge while idle
    @(negedge clk); wrAck = 1'b1; @(negedge clk); wrAck = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 idle", int'(wrReq), 0);
    check("R11 done kept", int'(done), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule